// File: doc/BRIEF.md
# Extended peripheral select decoder

This block sits between a small controller's I/O bus and a region of user programmable logic. Four I/O addresses are reserved for that logic. A control register holds a two-bit extension field that widens those four addresses into sixteen one-hot select lines. Each address picks a group of four lines and the extension field picks one line within the group. The block also gives the user logic qualified read and write strobes. These strobes are active only when one of the four reserved addresses is on the bus. The user logic builds its own registers, each enabled by one select line together with a qualified strobe.

A mode bit in the same control register changes the meaning of the four reserved addresses. When the bit is set, the addresses reach four real registers: two interrupt mask registers and two interrupt flag registers. A request input from the user logic sets each flag bit. The bus clears a flag bit by writing a one to it. An interrupt output is raised whenever a flag bit and its mask bit are both set.

The mode is held by a two-state machine. `ST_SELECT` is the reset state and routes the reserved addresses to the select lines. `ST_IRQ` routes them to the mask and flag registers. Transition `T_ENTER_IRQ` (`ST_SELECT` to `ST_IRQ`) happens on a control-register write with bit 7 set. Transition `T_LEAVE_IRQ` (`ST_IRQ` to `ST_SELECT`) happens on a control-register write with bit 7 clear. Every other cycle holds the state.

Top module: `xsel_decoder`

## Requirements
- R1: The control register sits at I/O address 0x13. Bit 7 is the mode bit (1 = interrupt mode) and bits 1:0 are the extension field. Both are writable and read back at that address. Bits 6:2 always read as zero.
- R2: After reset the mode bit, the extension field, both mask registers and both flag registers are zero. All select lines, both qualified strobes and the interrupt output are low.
- R3: In select mode, a read or write to reserved address 0x14+g (g = 0..3) with extension value e drives select line 4*g+e high. This happens combinationally, in the same cycle as the bus strobe.
- R4: With no bus read or write strobe active, every select line is low. At most one select line is ever high.
- R5: In select mode, the qualified read strobe equals the bus read strobe and the qualified write strobe equals the bus write strobe, but only while the address is one of 0x14..0x17. For any other address, the control address included, both qualified strobes stay low.
- R6: In select mode, the reserved addresses have no storage. Reads of them return 0x00, and writes to them change no mask or flag register.
- R7: In interrupt mode, all select lines and both qualified strobes stay low. Addresses 0x14, 0x15, 0x16 and 0x17 read and write mask[7:0], mask[15:8], flag[7:0] and flag[15:8] in that order.
- R8: Flag bit k is set at the clock edge where request input k is high. It is cleared when the bus writes a one to that bit in interrupt mode, and writing a zero leaves the bit unchanged. If a set and a clear hit the same bit in the same cycle, the set wins.
- R9: The interrupt output is high exactly when some flag bit k and mask bit k are both set.
- R10: The mode machine moves between `ST_SELECT` and `ST_IRQ` only through a control-register write, following bit 7 of the written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 6 | I/O address of the current access |
| io_rd | input | 1 | Bus read strobe |
| io_wr | input | 1 | Bus write strobe |
| io_wdata | input | 8 | Bus write data |
| irq_src | input | 16 | Interrupt requests from user logic, one per flag bit |
| sel | output | 16 | One-hot select lines to user logic |
| sel_rd | output | 1 | Qualified read strobe |
| sel_wr | output | 1 | Qualified write strobe |
| io_rdata | output | 8 | Read data for the control, mask and flag registers |
| irq_out | output | 1 | Interrupt request to the controller |

## Verification
The hardest case to reach is a request and a write-one-to-clear landing on the same flag bit in the same clock cycle. The bench gets there by raising one request input on the falling edge while it places a clearing write to the low flag address. Both events are then captured by the same rising edge, and the bit is read back afterwards. The lack of storage behind the reserved addresses in select mode cannot be seen directly, so the bench shows it indirectly. It writes all-ones to a reserved address in select mode, switches to interrupt mode, and confirms the mask value written earlier is unchanged.

// File: rtl/xsel_pkg.sv
package xsel_pkg;

    typedef enum logic [0:0] {
        ST_SELECT = 1'b0,
        ST_IRQ    = 1'b1
    } xsel_state_e;

endpackage

// File: rtl/xsel_ctrl.sv
module xsel_ctrl
    import xsel_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int EXT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output xsel_state_e       mode,
    output logic [EXT_W-1:0]  ext,
    output logic [DATA_W-1:0] rdata
);

    localparam int MODE_BIT = DATA_W - 1;

    xsel_state_e      state_q, state_d;
    logic [EXT_W-1:0] ext_q;

    // state register and extension field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SELECT;
            ext_q   <= '0;
        end else begin
            state_q <= state_d;
            if (wr_en) begin
                ext_q <= wdata[EXT_W-1:0];
            end
        end
    end

    // next state: T_ENTER_IRQ / T_LEAVE_IRQ
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SELECT: if (wr_en && wdata[MODE_BIT])  state_d = ST_IRQ;
            ST_IRQ:    if (wr_en && !wdata[MODE_BIT]) state_d = ST_SELECT;
            default:   state_d = ST_SELECT;
        endcase
    end

    // outputs
    always_comb begin
        mode  = state_q;
        ext   = ext_q;
        rdata = '0;
        unique case (state_q)
            ST_SELECT: rdata[MODE_BIT] = 1'b0;
            ST_IRQ:    rdata[MODE_BIT] = 1'b1;
            default:   rdata[MODE_BIT] = 1'b0;
        endcase
        rdata[EXT_W-1:0] = ext_q;
    end

endmodule

// File: rtl/xsel_decode.sv
module xsel_decode
    import xsel_pkg::*;
#(
    parameter int                  ADDR_W   = 6,
    parameter int                  N_GROUPS = 4,
    parameter int                  EXT_W    = 2,
    parameter logic [ADDR_W-1:0]   GRP_BASE = 6'h14,
    localparam int                 LINES    = 1 << EXT_W,
    localparam int                 SEL_W    = N_GROUPS * LINES,
    localparam int                 GRP_W    = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  xsel_state_e       mode,
    input  logic [EXT_W-1:0]  ext,
    output logic              grp_any,
    output logic [GRP_W-1:0]  grp_idx,
    output logic [SEL_W-1:0]  sel,
    output logic              sel_rd,
    output logic              sel_wr
);

    logic [N_GROUPS-1:0] hit;
    logic                sel_mode;
    logic                strobe;

    assign sel_mode = (mode == ST_SELECT);
    assign strobe   = io_rd | io_wr;

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        localparam logic [ADDR_W-1:0] ADDR_G = GRP_BASE + ADDR_W'(g);
        assign hit[g] = (io_addr == ADDR_G);
        for (genvar l = 0; l < LINES; l++) begin : g_line
            assign sel[g*LINES + l] = hit[g] & strobe & sel_mode
                                      & (ext == EXT_W'(l));
        end
    end

    always_comb begin
        grp_idx = '0;
        for (int g = 0; g < N_GROUPS; g++) begin
            if (hit[g]) grp_idx = GRP_W'(g);
        end
    end

    assign grp_any = |hit;
    assign sel_rd  = io_rd & grp_any & sel_mode;
    assign sel_wr  = io_wr & grp_any & sel_mode;

endmodule

// File: rtl/xsel_irq_bank.sv
module xsel_irq_bank #(
    parameter int  DATA_W   = 8,
    parameter int  N_GROUPS = 4,
    localparam int N_REG    = N_GROUPS / 2,
    localparam int IRQ_W    = N_REG * DATA_W,
    localparam int GRP_W    = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [GRP_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IRQ_W-1:0]  irq_src,
    output logic [DATA_W-1:0] rdata,
    output logic [IRQ_W-1:0]  mask_q,
    output logic [IRQ_W-1:0]  flag_q,
    output logic              irq_out
);

    for (genvar r = 0; r < N_REG; r++) begin : g_reg
        localparam logic [GRP_W-1:0] MASK_IDX = GRP_W'(r);
        localparam logic [GRP_W-1:0] FLAG_IDX = GRP_W'(r + N_REG);

        logic [DATA_W-1:0] clr;
        assign clr = (wr_en && idx == FLAG_IDX) ? wdata : '0;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[r*DATA_W +: DATA_W] <= '0;
                flag_q[r*DATA_W +: DATA_W] <= '0;
            end else begin
                if (wr_en && idx == MASK_IDX) begin
                    mask_q[r*DATA_W +: DATA_W] <= wdata;
                end
                flag_q[r*DATA_W +: DATA_W] <= (flag_q[r*DATA_W +: DATA_W] & ~clr)
                                             | irq_src[r*DATA_W +: DATA_W];
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int r = 0; r < N_REG; r++) begin
            if (idx == GRP_W'(r))         rdata = mask_q[r*DATA_W +: DATA_W];
            if (idx == GRP_W'(r + N_REG)) rdata = flag_q[r*DATA_W +: DATA_W];
        end
    end

    assign irq_out = |(flag_q & mask_q);

endmodule

// File: rtl/xsel_decoder.sv
module xsel_decoder
    import xsel_pkg::*;
#(
    parameter int                ADDR_W    = 6,
    parameter int                DATA_W    = 8,
    parameter int                N_GROUPS  = 4,
    parameter int                EXT_W     = 2,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h13,
    parameter logic [ADDR_W-1:0] GRP_BASE  = 6'h14,
    localparam int               SEL_W     = N_GROUPS * (1 << EXT_W),
    localparam int               IRQ_W     = (N_GROUPS / 2) * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic [IRQ_W-1:0]  irq_src,
    output logic [SEL_W-1:0]  sel,
    output logic              sel_rd,
    output logic              sel_wr,
    output logic [DATA_W-1:0] io_rdata,
    output logic              irq_out
);

    localparam int GRP_W = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1;

    xsel_state_e       mode_w;
    logic [EXT_W-1:0]  ext_w;
    logic [DATA_W-1:0] ctrl_rdata;
    logic [DATA_W-1:0] bank_rdata;
    logic              grp_any;
    logic [GRP_W-1:0]  grp_idx;
    logic [IRQ_W-1:0]  mask_w;
    logic [IRQ_W-1:0]  flag_w;
    logic              ctrl_hit;
    logic              irq_mode;

    assign ctrl_hit = (io_addr == CTRL_ADDR);
    assign irq_mode = (mode_w == ST_IRQ);

    xsel_ctrl #(
        .DATA_W (DATA_W),
        .EXT_W  (EXT_W)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (io_wr & ctrl_hit),
        .wdata (io_wdata),
        .mode  (mode_w),
        .ext   (ext_w),
        .rdata (ctrl_rdata)
    );

    xsel_decode #(
        .ADDR_W   (ADDR_W),
        .N_GROUPS (N_GROUPS),
        .EXT_W    (EXT_W),
        .GRP_BASE (GRP_BASE)
    ) u_decode (
        .io_addr (io_addr),
        .io_rd   (io_rd),
        .io_wr   (io_wr),
        .mode    (mode_w),
        .ext     (ext_w),
        .grp_any (grp_any),
        .grp_idx (grp_idx),
        .sel     (sel),
        .sel_rd  (sel_rd),
        .sel_wr  (sel_wr)
    );

    xsel_irq_bank #(
        .DATA_W   (DATA_W),
        .N_GROUPS (N_GROUPS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (io_wr & grp_any & irq_mode),
        .idx     (grp_idx),
        .wdata   (io_wdata),
        .irq_src (irq_src),
        .rdata   (bank_rdata),
        .mask_q  (mask_w),
        .flag_q  (flag_w),
        .irq_out (irq_out)
    );

    always_comb begin
        io_rdata = '0;
        if (ctrl_hit)                 io_rdata = ctrl_rdata;
        else if (grp_any && irq_mode) io_rdata = bank_rdata;
    end

endmodule

// File: rtl/xsel_chk.sv
module xsel_chk #(
    parameter int SEL_W = 16,
    parameter int IRQ_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             io_rd,
    input logic             io_wr,
    input logic [SEL_W-1:0] sel,
    input logic             sel_rd,
    input logic             sel_wr,
    input logic             irq_mode,
    input logic [IRQ_W-1:0] irq_src,
    input logic [IRQ_W-1:0] flag,
    input logic             irq_out
);

    // R4
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R4
    sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd || io_wr) |-> (sel == '0));

    // R5
    rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_rd |-> io_rd);

    // R5
    wr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |-> io_wr);

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mode |-> (sel == '0 && !sel_rd && !sel_wr));

    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_src != '0) |=> ((flag & $past(irq_src)) == $past(irq_src)));

    // R9
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (flag != '0));

endmodule

bind xsel_decoder xsel_chk #(
    .SEL_W (SEL_W),
    .IRQ_W (IRQ_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .sel      (sel),
    .sel_rd   (sel_rd),
    .sel_wr   (sel_wr),
    .irq_mode (irq_mode),
    .irq_src  (irq_src),
    .flag     (flag_w),
    .irq_out  (irq_out)
);

// File: tb/tb_xsel_decoder.sv
`timescale 1ns/1ps
module tb_xsel_decoder;

    localparam logic [5:0] A_CTRL = 6'h13;
    localparam logic [5:0] A_BASE = 6'h14;
    localparam logic [5:0] A_MLO  = 6'h14;
    localparam logic [5:0] A_MHI  = 6'h15;
    localparam logic [5:0] A_FLO  = 6'h16;
    localparam logic [5:0] A_FHI  = 6'h17;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  io_addr;
    logic        io_rd;
    logic        io_wr;
    logic [7:0]  io_wdata;
    logic [15:0] irq_src;
    logic [15:0] sel;
    logic        sel_rd;
    logic        sel_wr;
    logic [7:0]  io_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [15:0] s_sel;
    logic        s_rd, s_wr;
    logic [7:0]  s_data;

    always #2.5 clk = ~clk;

    xsel_decoder dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_addr  (io_addr),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .io_wdata (io_wdata),
        .irq_src  (irq_src),
        .sel      (sel),
        .sel_rd   (sel_rd),
        .sel_wr   (sel_wr),
        .io_rdata (io_rdata),
        .irq_out  (irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [5:0] a);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        s_data = io_rdata; s_sel = sel; s_rd = sel_rd; s_wr = sel_wr;
        @(posedge clk);
        #1;
        io_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        #1;
        s_sel = sel; s_rd = sel_rd; s_wr = sel_wr;
        @(posedge clk);
        #1;
        io_wr = 1'b0;
    endtask

    task automatic t_reset();
        check("R2 sel", 32'(sel), 0);
        check("R2 strobes", {30'd0, sel_rd, sel_wr}, 0);
        check("R2 irq_out", 32'(irq_out), 0);
        bus_read(A_CTRL);
        check("R2 ctrl", 32'(s_data), 0);
        bus_read(A_FLO);
        check("R2 flag lo in select mode", 32'(s_data), 0);
    endtask

    task automatic t_ctrl();
        bus_write(A_CTRL, 8'hFF);
        bus_read(A_CTRL);
        check("R1 reserved bits zero", 32'(s_data), 32'h83);
        check("R10 ST_IRQ entered, no select", 32'(s_sel), 0);
        bus_write(A_CTRL, 8'h7E);
        bus_read(A_CTRL);
        check("R1 R10 leave irq, ext=2", 32'(s_data), 32'h02);
    endtask

    task automatic t_sweep();
        for (int e = 0; e < 4; e++) begin
            bus_write(A_CTRL, 8'(e));
            for (int g = 0; g < 4; g++) begin
                bus_read(A_BASE + 6'(g));
                check("R3 read select", 32'(s_sel), 32'(16'd1 << (4*g + e)));
                check("R5 read strobes", {30'd0, s_rd, s_wr}, 32'h2);
                check("R6 read data zero", 32'(s_data), 0);
                bus_write(A_BASE + 6'(g), 8'h5A);
                check("R3 write select", 32'(s_sel), 32'(16'd1 << (4*g + e)));
                check("R5 write strobes", {30'd0, s_rd, s_wr}, 32'h1);
            end
        end
    endtask

    task automatic t_idle();
        @(negedge clk);
        io_addr = A_BASE;
        #1;
        check("R4 no strobe no select", 32'(sel), 0);
        check("R5 no strobe", {30'd0, sel_rd, sel_wr}, 0);
        bus_read(6'h20);
        check("R4 foreign addr select", 32'(s_sel), 0);
        check("R5 foreign addr strobe", 32'(s_rd), 0);
        bus_write(6'h18, 8'h00);
        check("R5 addr above range", 32'(s_wr), 0);
        bus_read(A_CTRL);
        check("R5 ctrl addr no strobe", {30'd0, s_rd, s_wr}, 0);
    endtask

    task automatic t_irq_regs();
        bus_write(A_CTRL, 8'h80);
        bus_write(A_MLO, 8'hA5);
        check("R7 write quiet sel", 32'(s_sel), 0);
        check("R7 write quiet strobe", 32'(s_wr), 0);
        bus_write(A_MHI, 8'h3C);
        bus_read(A_MLO);
        check("R7 mask lo", 32'(s_data), 32'hA5);
        check("R7 read quiet", {14'd0, s_sel, s_rd, s_wr}, 0);
        bus_read(A_MHI);
        check("R7 mask hi", 32'(s_data), 32'h3C);
    endtask

    task automatic t_flags();
        @(negedge clk);
        irq_src = 16'h0101;
        @(posedge clk);
        #1;
        irq_src = '0;
        check("R9 irq on masked flag", 32'(irq_out), 1);
        bus_read(A_FLO);
        check("R8 flag lo set", 32'(s_data), 32'h01);
        bus_read(A_FHI);
        check("R8 flag hi set", 32'(s_data), 32'h01);
        bus_write(A_FLO, 8'h01);
        bus_read(A_FLO);
        check("R8 w1c", 32'(s_data), 0);
        check("R9 unmasked flag no irq", 32'(irq_out), 0);
        // set and clear in one cycle
        @(negedge clk);
        irq_src = 16'h0008; io_addr = A_FLO; io_wdata = 8'h08; io_wr = 1'b1;
        @(posedge clk);
        #1;
        irq_src = '0; io_wr = 1'b0;
        bus_read(A_FLO);
        check("R8 set beats clear", 32'(s_data), 32'h08);
        bus_write(A_FLO, 8'h00);
        bus_read(A_FLO);
        check("R8 write zero keeps", 32'(s_data), 32'h08);
        bus_write(A_FLO, 8'h08);
        bus_write(A_FHI, 8'h01);
        bus_read(A_FHI);
        check("R8 hi cleared", 32'(s_data), 0);
        bus_write(A_MHI, 8'h01);
        @(negedge clk);
        irq_src = 16'h0100;
        @(posedge clk);
        #1;
        irq_src = '0;
        check("R9 hi mask irq", 32'(irq_out), 1);
        bus_write(A_MHI, 8'h00);
        #1;
        check("R9 mask removed", 32'(irq_out), 0);
    endtask

    task automatic t_nostore();
        bus_write(A_CTRL, 8'h00);
        bus_write(A_MLO, 8'hFF);
        bus_write(A_FHI, 8'hFF);
        bus_write(A_CTRL, 8'h80);
        bus_read(A_MLO);
        check("R6 mask untouched", 32'(s_data), 32'hA5);
        bus_read(A_FHI);
        check("R6 flag untouched", 32'(s_data), 32'h01);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; io_addr = '0; io_rd = 1'b0; io_wr = 1'b0;
        io_wdata = '0; irq_src = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_ctrl();
        t_sweep();
        t_idle();
        t_irq_regs();
        t_flags();
        t_nostore();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule